// File: doc/BRIEF.md
# DMA Major-Loop Iteration and Interrupt Controller

This block keeps the outer iteration count of a single DMA channel and produces the side effects that follow from that count. A descriptor load writes a begin count, a current count and three control bits into the block. After that, each strobe from the transfer engine marking the end of an inner (minor) loop lowers the current count by one. When the lowered count reaches zero, the block reloads the current count from the begin count so the next outer loop can run. In the same cycle it can raise an interrupt request and pulse a clear of the channel's hardware-request enable.

The block can also raise an interrupt at the halfway mark, where the lowered count equals the begin count shifted right by one bit. This supports ping-pong buffering. The block also watches a software start flag, which asks for service just as a hardware request does. When the engine reports that the channel has begun executing, the block returns a one-cycle acknowledge that clears that flag. Address generation, bus traffic and arbitration between channels belong to other blocks.

Top module: `dma_major_loop_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears all of its registers. On the next cycle `citer_out` is 0 and `irq_pulse`, `irq_is_half`, `irq_is_major`, `hwreq_clr`, `svc_req` and `start_ack` are all 0.
- R2: A cycle with `load_valid` high captures the begin count, the current count and the three control bits (`half_en`, `major_en`, `dreq_en`). From the next cycle `citer_out` equals `load_citer`. A `minor_done` in that same cycle is ignored.
- R3: A `minor_done` cycle without a load sets `citer_out` on the next cycle to the old value minus one, modulo 2^15, unless R4 applies. From 0 the count wraps to 32767.
- R4: When the lowered count is 0, `citer_out` on the next cycle equals the begin count instead.
- R5: If `major_en` is set and the lowered count is 0, `irq_pulse` and `irq_is_major` are 1 for exactly the next cycle.
- R6: If `half_en` is set and the lowered count equals the begin count shifted right by one bit, `irq_pulse` and `irq_is_half` are 1 for exactly the next cycle.
- R7: With the begin count and the current count both 1 and `half_en` set, a single `minor_done` raises the half interrupt, because 0 equals 1 shifted right by one.
- R8: If the half and major conditions hold on the same strobe, `irq_pulse` is 1 for one cycle with both `irq_is_half` and `irq_is_major` set. Whenever `irq_pulse` is 0, both status bits are 0.
- R9: If `dreq_en` is set and the lowered count is 0, `hwreq_clr` is 1 for exactly the next cycle. If `dreq_en` is clear, `hwreq_clr` stays 0.
- R10: With a begin count of 0, neither interrupt is raised, whatever the control bits.
- R11: `svc_req` equals, one cycle later, `sw_start` OR `hw_req`.
- R12: `start_ack` is 1 for exactly the cycle after a cycle in which `exec_begin` and `sw_start` are both 1. `exec_begin` without `sw_start` gives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Descriptor load strobe |
| load_biter | input | 15 | Begin count to load |
| load_citer | input | 15 | Current count to load |
| load_half_en | input | 1 | Half-point interrupt enable to load |
| load_major_en | input | 1 | Major-complete interrupt enable to load |
| load_dreq_en | input | 1 | Auto-clear of hardware request enable to load |
| minor_done | input | 1 | End of one minor loop |
| sw_start | input | 1 | Software start flag |
| hw_req | input | 1 | Hardware service request line |
| exec_begin | input | 1 | Engine begins executing this channel |
| citer_out | output | 15 | Current major count |
| irq_pulse | output | 1 | Interrupt request pulse |
| irq_is_half | output | 1 | Interrupt cause: halfway point |
| irq_is_major | output | 1 | Interrupt cause: major loop complete |
| hwreq_clr | output | 1 | Clear strobe for the hardware-request enable |
| svc_req | output | 1 | Channel is requesting service |
| start_ack | output | 1 | Acknowledge that clears the start flag |

## Verification
Every output comes from a register, so each result is due one clock edge after the cycle holding its stimulus. This covers the count update, both interrupt causes, the enable-clear strobe, the service request and the start acknowledge. The bench changes inputs on falling edges and advances a behavioural reference model on each rising edge. On the following falling edge it compares every output against that model. Directed checks then sample on the first falling edge after the strobe for the halfway point, the reload, the combined interrupt, the zero begin count and the load-versus-strobe collision.

// File: rtl/dml_pkg.sv
package dml_pkg;
  typedef struct packed {
    logic half_en;
    logic major_en;
    logic dreq_en;
  } dml_ctrl_t;

  typedef struct packed {
    logic irq;
    logic is_half;
    logic is_major;
    logic hw_clr;
  } dml_evt_t;
endpackage

// File: rtl/dml_iter_count.sv
module dml_iter_count #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_biter,
  input  logic [CNT_W-1:0] load_citer,
  input  logic             step,
  output logic [CNT_W-1:0] citer_q,
  output logic [CNT_W-1:0] biter_q,
  output logic [CNT_W-1:0] next_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign next_cnt = citer_q - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      citer_q <= '0;
      biter_q <= '0;
    end else if (load) begin
      citer_q <= load_citer;
      biter_q <= load_biter;
    end else if (step) begin
      citer_q <= (next_cnt == '0) ? biter_q : next_cnt;
    end
  end
endmodule

// File: rtl/dml_event_gen.sv
module dml_event_gen
  import dml_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] next_cnt,
  input  logic [CNT_W-1:0] biter,
  input  dml_ctrl_t        ctrl,
  output dml_evt_t         evt
);
  logic hit_zero, hit_half, cfg_ok, half_fire, major_fire;

  assign cfg_ok     = (biter != '0);
  assign hit_zero   = step && (next_cnt == '0);
  assign hit_half   = step && (next_cnt == (biter >> 1));
  assign half_fire  = hit_half && ctrl.half_en && cfg_ok;
  assign major_fire = hit_zero && ctrl.major_en && cfg_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt <= '0;
    end else begin
      evt.irq      <= half_fire || major_fire;
      evt.is_half  <= half_fire;
      evt.is_major <= major_fire;
      evt.hw_clr   <= hit_zero && ctrl.dreq_en;
    end
  end
endmodule

// File: rtl/dml_start_hs.sv
module dml_start_hs (
  input  logic clk,
  input  logic rst,
  input  logic sw_start,
  input  logic hw_req,
  input  logic exec_begin,
  output logic svc_req,
  output logic start_ack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      svc_req   <= 1'b0;
      start_ack <= 1'b0;
    end else begin
      svc_req   <= sw_start || hw_req;
      start_ack <= sw_start && exec_begin;
    end
  end
endmodule

// File: rtl/dma_major_loop_ctl.sv
module dma_major_loop_ctl
  import dml_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_biter,
  input  logic [CNT_W-1:0] load_citer,
  input  logic             load_half_en,
  input  logic             load_major_en,
  input  logic             load_dreq_en,
  input  logic             minor_done,
  input  logic             sw_start,
  input  logic             hw_req,
  input  logic             exec_begin,
  output logic [CNT_W-1:0] citer_out,
  output logic             irq_pulse,
  output logic             irq_is_half,
  output logic             irq_is_major,
  output logic             hwreq_clr,
  output logic             svc_req,
  output logic             start_ack
);
  dml_ctrl_t        ctrl_q;
  dml_evt_t         evt;
  logic [CNT_W-1:0] biter_q;
  logic [CNT_W-1:0] next_cnt;
  logic             step;

  assign step = minor_done && !load_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (load_valid) begin
      ctrl_q.half_en  <= load_half_en;
      ctrl_q.major_en <= load_major_en;
      ctrl_q.dreq_en  <= load_dreq_en;
    end
  end

  dml_iter_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .load       (load_valid),
    .load_biter (load_biter),
    .load_citer (load_citer),
    .step       (step),
    .citer_q    (citer_out),
    .biter_q    (biter_q),
    .next_cnt   (next_cnt)
  );

  dml_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .next_cnt (next_cnt),
    .biter    (biter_q),
    .ctrl     (ctrl_q),
    .evt      (evt)
  );

  assign irq_pulse    = evt.irq;
  assign irq_is_half  = evt.is_half;
  assign irq_is_major = evt.is_major;
  assign hwreq_clr    = evt.hw_clr;

  dml_start_hs u_start (
    .clk        (clk),
    .rst        (rst),
    .sw_start   (sw_start),
    .hw_req     (hw_req),
    .exec_begin (exec_begin),
    .svc_req    (svc_req),
    .start_ack  (start_ack)
  );
endmodule

// File: rtl/dml_checker.sv
module dml_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             load_valid,
  input logic             minor_done,
  input logic [CNT_W-1:0] load_citer,
  input logic [CNT_W-1:0] citer_out,
  input logic [CNT_W-1:0] biter,
  input logic             dreq_en,
  input logic             irq_pulse,
  input logic             irq_is_half,
  input logic             irq_is_major,
  input logic             hwreq_clr,
  input logic             sw_start,
  input logic             exec_begin,
  input logic             start_ack
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_valid |=> (citer_out == $past(load_citer)));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (minor_done && !load_valid && citer_out > ONE) |=> (citer_out == $past(citer_out) - ONE));

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (minor_done && !load_valid && citer_out == ONE) |=> (citer_out == $past(biter)));

  assert_cause_set_R8: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (irq_is_half || irq_is_major));

  assert_cause_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_pulse |-> (!irq_is_half && !irq_is_major));

  assert_clr_gated_R9: assert property (@(posedge clk) disable iff (rst)
    hwreq_clr |-> $past(dreq_en));

  assert_zero_begin_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(biter) == '0) |-> !irq_pulse);

  assert_ack_cause_R12: assert property (@(posedge clk) disable iff (rst)
    start_ack |-> $past(sw_start && exec_begin));
endmodule

bind dma_major_loop_ctl dml_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .load_valid   (load_valid),
  .minor_done   (minor_done),
  .load_citer   (load_citer),
  .citer_out    (citer_out),
  .biter        (biter_q),
  .dreq_en      (ctrl_q.dreq_en),
  .irq_pulse    (irq_pulse),
  .irq_is_half  (irq_is_half),
  .irq_is_major (irq_is_major),
  .hwreq_clr    (hwreq_clr),
  .sw_start     (sw_start),
  .exec_begin   (exec_begin),
  .start_ack    (start_ack)
);

// File: tb/dma_major_loop_ctl_tb.sv
`timescale 1ns/1ps
module dma_major_loop_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_valid = 1'b0;
  logic [14:0] load_biter = '0;
  logic [14:0] load_citer = '0;
  logic        load_half_en = 1'b0, load_major_en = 1'b0, load_dreq_en = 1'b0;
  logic        minor_done = 1'b0, sw_start = 1'b0, hw_req = 1'b0, exec_begin = 1'b0;
  logic [14:0] citer_out;
  logic        irq_pulse, irq_is_half, irq_is_major, hwreq_clr, svc_req, start_ack;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_major_loop_ctl u_dut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_biter(load_biter),
    .load_citer(load_citer), .load_half_en(load_half_en), .load_major_en(load_major_en),
    .load_dreq_en(load_dreq_en), .minor_done(minor_done), .sw_start(sw_start),
    .hw_req(hw_req), .exec_begin(exec_begin), .citer_out(citer_out),
    .irq_pulse(irq_pulse), .irq_is_half(irq_is_half), .irq_is_major(irq_is_major),
    .hwreq_clr(hwreq_clr), .svc_req(svc_req), .start_ack(start_ack)
  );

  // behavioural reference model
  int m_citer = 0, m_biter = 0;
  bit m_half = 0, m_maj = 0, m_dreq = 0;
  bit m_irq = 0, m_ih = 0, m_im = 0, m_clr = 0, m_svc = 0, m_ack = 0;

  always @(posedge clk) begin
    int nxt;
    bit hf, mf;
    if (rst) begin
      m_citer = 0; m_biter = 0; m_half = 0; m_maj = 0; m_dreq = 0;
      m_irq = 0; m_ih = 0; m_im = 0; m_clr = 0; m_svc = 0; m_ack = 0;
    end else begin
      m_svc = sw_start || hw_req;
      m_ack = sw_start && exec_begin;
      m_irq = 0; m_ih = 0; m_im = 0; m_clr = 0;
      if (load_valid) begin
        m_citer = int'(load_citer); m_biter = int'(load_biter);
        m_half = load_half_en; m_maj = load_major_en; m_dreq = load_dreq_en;
      end else if (minor_done) begin
        nxt = (m_citer + 32767) % 32768;
        hf = m_half && (nxt == m_biter / 2) && (m_biter != 0);
        mf = m_maj && (nxt == 0) && (m_biter != 0);
        m_ih = hf; m_im = mf; m_irq = hf || mf;
        m_clr = m_dreq && (nxt == 0);
        m_citer = (nxt == 0) ? m_biter : nxt;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(citer_out) == m_citer, "R3 model citer", int'(citer_out), m_citer);
      chk(irq_pulse == m_irq, "R5 model irq", int'(irq_pulse), int'(m_irq));
      chk(irq_is_half == m_ih, "R6 model half cause", int'(irq_is_half), int'(m_ih));
      chk(irq_is_major == m_im, "R5 model major cause", int'(irq_is_major), int'(m_im));
      chk(hwreq_clr == m_clr, "R9 model clear", int'(hwreq_clr), int'(m_clr));
      chk(svc_req == m_svc, "R11 model svc", int'(svc_req), int'(m_svc));
      chk(start_ack == m_ack, "R12 model ack", int'(start_ack), int'(m_ack));
    end
  end

  task automatic load(input int b, input int c, input bit h, input bit m, input bit d);
    @(negedge clk);
    load_valid = 1; load_biter = 15'(b); load_citer = 15'(c);
    load_half_en = h; load_major_en = m; load_dreq_en = d;
    @(negedge clk);
    load_valid = 0;
  endtask

  task automatic step();
    @(negedge clk);
    minor_done = 1;
    @(negedge clk);
    minor_done = 0;
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(citer_out == 0 && !irq_pulse && !hwreq_clr && !svc_req && !start_ack,
        "R1 reset outputs", int'(citer_out), 0);

    // R2 load
    load(4, 4, 1, 1, 1);
    chk(citer_out == 15'd4, "R2 load citer", int'(citer_out), 4);
    // R3 decrement, R6 half at 2
    step();
    chk(citer_out == 15'd3, "R3 decrement", int'(citer_out), 3);
    chk(!irq_pulse, "R6 no early half", int'(irq_pulse), 0);
    step();
    chk(irq_pulse && irq_is_half && !irq_is_major, "R6 half irq", int'(irq_is_half), 1);
    step();
    chk(!irq_pulse, "R6 half pulse one cycle", int'(irq_pulse), 0);
    step();
    chk(citer_out == 15'd4, "R4 reload", int'(citer_out), 4);
    chk(irq_is_major && irq_pulse, "R5 major irq", int'(irq_is_major), 1);
    chk(hwreq_clr, "R9 clear on zero", int'(hwreq_clr), 1);
    @(negedge clk);
    chk(!hwreq_clr && !irq_pulse, "R9 clear one cycle", int'(hwreq_clr), 0);

    // R7 begin=current=1, half only, no dreq
    load(1, 1, 1, 0, 0);
    step();
    chk(irq_pulse && irq_is_half && !irq_is_major, "R7 half at one", int'(irq_is_half), 1);
    chk(!hwreq_clr, "R9 no clear when disabled", int'(hwreq_clr), 0);

    // R8 both causes
    load(1, 1, 1, 1, 0);
    step();
    chk(irq_pulse && irq_is_half && irq_is_major, "R8 merged causes", int'({irq_is_half, irq_is_major}), 3);

    // R10 zero begin count
    load(0, 2, 1, 1, 1);
    step();
    chk(!irq_pulse, "R10 no irq step1", int'(irq_pulse), 0);
    step();
    chk(!irq_pulse && citer_out == 0, "R10 no irq at zero", int'(irq_pulse), 0);
    step();
    chk(citer_out == 15'd32767, "R3 wrap from zero", int'(citer_out), 32767);

    // R2 load wins over strobe
    @(negedge clk);
    load_valid = 1; load_biter = 15'd9; load_citer = 15'd7; minor_done = 1;
    load_half_en = 0; load_major_en = 1; load_dreq_en = 0;
    @(negedge clk);
    load_valid = 0; minor_done = 0;
    chk(citer_out == 15'd7, "R2 load beats strobe", int'(citer_out), 7);

    // R11 / R12
    @(negedge clk); hw_req = 1;
    @(negedge clk); hw_req = 0;
    chk(svc_req, "R11 hw request", int'(svc_req), 1);
    exec_begin = 1;
    @(negedge clk); exec_begin = 0;
    chk(!start_ack, "R12 no ack without start", int'(start_ack), 0);
    sw_start = 1;
    @(negedge clk);
    chk(svc_req, "R11 sw start request", int'(svc_req), 1);
    exec_begin = 1;
    @(negedge clk); exec_begin = 0; sw_start = 0;
    chk(start_ack, "R12 ack", int'(start_ack), 1);
    @(negedge clk);
    chk(!start_ack, "R12 ack one cycle", int'(start_ack), 0);

    // mixed stream against the model
    load(6, 6, 1, 1, 1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      minor_done = (i % 3) != 1;
      sw_start = (i % 7) == 2;
      exec_begin = (i % 5) == 2;
      hw_req = (i % 11) == 4;
    end
    @(negedge clk);
    minor_done = 0; sw_start = 0; exec_begin = 0; hw_req = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule